// File: doc/BRIEF.md
# Block-Window Raster Address Generator

This block sets the order in which pixels are read out for one frame of a 128 by 128 pixel array. The array is split into a 16 by 16 grid of blocks, and each block is 8 by 8 pixels. Two 8-bit window registers name a start block and an end block. The block then walks every pixel in that rectangle. It moves across the columns of one row, then goes on to the next row, and it emits one pixel on every clock. When both registers are zero, the window is the whole array.

An optional reference line can come before the image. It is 128 dark pixels, and it is requested by driving an active-low enable. For each emitted pixel the block gives row and column addresses, a dark-line flag and a one-clock strobe. An active-frame flag covers the whole frame, and a single-cycle done pulse marks its end. A pulse on the start input starts a frame. The window and the dark enable are captured at that moment, and they hold until the frame ends.

The controller has four states:
- `ST_IDLE`: waits for a start pulse.
- `ST_DARK`: emits the dark reference line.
- `ST_SCAN`: emits the window pixels.
- `ST_DONE`: the one-cycle done state.

Its transitions are:
- IDLE to DARK, on a start pulse with the dark line enabled.
- IDLE to SCAN, on a start pulse with the dark line disabled.
- DARK to SCAN, after column 127 of the dark line.
- SCAN to SCAN, on each pixel that is not the last one. At the last column of a row, the row advances and the column reloads.
- SCAN to DONE, after the last column of the last window row.
- DONE to IDLE, always.

Top module: `raster_win_gen`

## Requirements
- R1: In the window registers, bits 3:0 hold a block column and bits 7:4 hold a block row. The first image pixel is at column 8·xs and row 8·ys. The last image pixel is at column 8·xe−1 and row 8·ye−1.
- R2: With both window registers at 00h, the image covers columns 0..127 and rows 0..127.
- R3: On either axis, an end nibble that is not greater than the start nibble (zero included) counts as 16 on that axis. For example, start 00h with end 10h scans columns 0..127 and rows 0..7.
- R4: Pixels come one per clock with no gaps. Within a row the column rises by one each clock. Rows follow in rising order, so the pixel count equals the window area.
- R5: With `dark_en_n` low at frame start, 128 pixels with `dark_line` high come before the image. They use columns 0..127, and the row output holds the first window row. With `dark_en_n` high, no dark pixel is emitted.
- R6: `pix_strobe` is high for exactly one clock per emitted pixel. `frame_active` is high from the first pixel through the done cycle, and low otherwise.
- R7: `frame_done` is high for exactly one clock. That clock is the one right after the last image pixel.
- R8: The window registers and `dark_en_n` are captured only when a frame starts. A start pulse or a register change while a frame is running has no effect on that frame, and it starts no new frame.
- R9: While `rst_n` is low, `pix_strobe`, `dark_line`, `frame_active` and `frame_done` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| frame_start | input | 1 | One-clock pulse that starts a frame when idle |
| win_start | input | 8 | Start block: bits 7:4 row, bits 3:0 column |
| win_end | input | 8 | End block: bits 7:4 row, bits 3:0 column |
| dark_en_n | input | 1 | Low requests the dark reference line |
| row | output | 7 | Row address of the current pixel |
| col | output | 7 | Column address of the current pixel |
| dark_line | output | 1 | Current pixel belongs to the dark line |
| pix_strobe | output | 1 | One clock per emitted pixel |
| frame_active | output | 1 | Frame in progress, including the done cycle |
| frame_done | output | 1 | One-clock pulse after the last pixel |

## Verification
The scan is tried with several windows, and each one tells a different case apart:
- The full array, which separates the all-zero default.
- An interior window with distinct start and end nibbles on both axes, which shows whether the nibble order and the scaling by 8 are right.
- An end nibble of zero on one axis only.
- End nibbles below the start on both axes.

Frames with the dark line enabled, one of them with a window at the bottom edge, check that the reference row comes first and that the row output holds the first window row. A frame disturbed mid-scan by new register values and a second start pulse shows whether the inputs are captured only at frame start.

// File: rtl/rwg_pkg.sv
package rwg_pkg;
    localparam int BLK_W = 4;
    localparam int SUB_W = 3;
    localparam int POS_W = BLK_W + SUB_W;
    localparam int REG_W = 2 * BLK_W;
    localparam int NAXES = 2;

    typedef logic [POS_W-1:0] pos_t;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_DARK,
        ST_SCAN,
        ST_DONE
    } scan_st_e;
endpackage

// File: rtl/rwg_bounds.sv
module rwg_bounds
    import rwg_pkg::*;
(
    input  logic [REG_W-1:0]            win_start,
    input  logic [REG_W-1:0]            win_end,
    output logic [NAXES-1:0][POS_W-1:0] first_o,
    output logic [NAXES-1:0][POS_W-1:0] last_o
);
    localparam logic [BLK_W:0] FULL_BLK = (BLK_W+1)'(1 << BLK_W);

    for (genvar a = 0; a < NAXES; a++) begin : g_axis
        logic [BLK_W-1:0] s_nib;
        logic [BLK_W-1:0] e_nib;
        logic [BLK_W:0]   e_eff;
        logic [POS_W:0]   lim;

        assign s_nib = win_start[a*BLK_W +: BLK_W];
        assign e_nib = win_end[a*BLK_W +: BLK_W];
        // an end that does not lie past the start stretches to the array edge
        assign e_eff = (e_nib > s_nib) ? {1'b0, e_nib} : FULL_BLK;
        assign lim   = {e_eff, {SUB_W{1'b0}}} - (POS_W+1)'(1);

        assign first_o[a] = {s_nib, {SUB_W{1'b0}}};
        assign last_o[a]  = lim[POS_W-1:0];
    end
endmodule

// File: rtl/rwg_axis.sv
module rwg_axis #(
    parameter int W = 7
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         inc,
    output logic [W-1:0] val
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            val <= '0;
        end else if (load) begin
            val <= load_val;
        end else if (inc) begin
            val <= val + 1'b1;
        end
    end
endmodule

// File: rtl/raster_win_gen.sv
module raster_win_gen
    import rwg_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             frame_start,
    input  logic [REG_W-1:0] win_start,
    input  logic [REG_W-1:0] win_end,
    input  logic             dark_en_n,
    output logic [POS_W-1:0] row,
    output logic [POS_W-1:0] col,
    output logic             dark_line,
    output logic             pix_strobe,
    output logic             frame_active,
    output logic             frame_done
);
    localparam pos_t LINE_LAST = '1;
    localparam int   AX_COL    = 0;
    localparam int   AX_ROW    = 1;

    scan_st_e st, st_nxt;

    logic [NAXES-1:0][POS_W-1:0] bnd_first, bnd_last;
    pos_t c_first_q, c_last_q, r_last_q;
    pos_t col_q, row_q, col_ldv, row_ldv;
    logic col_ld, col_inc, row_ld, row_inc, latch;

    rwg_bounds u_bounds (
        .win_start (win_start),
        .win_end   (win_end),
        .first_o   (bnd_first),
        .last_o    (bnd_last)
    );

    rwg_axis #(.W(POS_W)) u_col (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (col_ld),
        .load_val (col_ldv),
        .inc      (col_inc),
        .val      (col_q)
    );

    rwg_axis #(.W(POS_W)) u_row (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (row_ld),
        .load_val (row_ldv),
        .inc      (row_inc),
        .val      (row_q)
    );

    // window limits held for the whole frame
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c_first_q <= '0;
            c_last_q  <= '0;
            r_last_q  <= '0;
        end else if (latch) begin
            c_first_q <= bnd_first[AX_COL];
            c_last_q  <= bnd_last[AX_COL];
            r_last_q  <= bnd_last[AX_ROW];
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st <= ST_IDLE;
        end else begin
            st <= st_nxt;
        end
    end

    // next state and counter control
    always_comb begin
        st_nxt  = st;
        latch   = 1'b0;
        col_ld  = 1'b0;
        col_inc = 1'b0;
        col_ldv = c_first_q;
        row_ld  = 1'b0;
        row_inc = 1'b0;
        row_ldv = bnd_first[AX_ROW];
        unique case (st)
            ST_IDLE: begin
                if (frame_start) begin
                    latch   = 1'b1;
                    col_ld  = 1'b1;
                    row_ld  = 1'b1;
                    col_ldv = dark_en_n ? bnd_first[AX_COL] : '0;
                    st_nxt  = dark_en_n ? ST_SCAN : ST_DARK;
                end
            end
            ST_DARK: begin
                if (col_q == LINE_LAST) begin
                    col_ld = 1'b1;
                    st_nxt = ST_SCAN;
                end else begin
                    col_inc = 1'b1;
                end
            end
            ST_SCAN: begin
                if (col_q == c_last_q) begin
                    if (row_q == r_last_q) begin
                        st_nxt = ST_DONE;
                    end else begin
                        row_inc = 1'b1;
                        col_ld  = 1'b1;
                    end
                end else begin
                    col_inc = 1'b1;
                end
            end
            ST_DONE: begin
                st_nxt = ST_IDLE;
            end
            default: st_nxt = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        row          = row_q;
        col          = col_q;
        dark_line    = (st == ST_DARK);
        pix_strobe   = (st == ST_DARK) || (st == ST_SCAN);
        frame_done   = (st == ST_DONE);
        frame_active = (st != ST_IDLE);
    end
endmodule

// File: rtl/rwg_chk.sv
module rwg_chk
    import rwg_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic [POS_W-1:0] row,
    input logic [POS_W-1:0] col,
    input logic             dark_line,
    input logic             pix_strobe,
    input logic             frame_active,
    input logic             frame_done
);
    // R7
    done_after_pixel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |-> ($past(pix_strobe) && !pix_strobe));

    // R7
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |=> !frame_done);

    // R6
    strobe_in_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pix_strobe |-> frame_active);

    // R5
    dark_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dark_line |-> pix_strobe);

    // R4
    col_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_strobe && $past(pix_strobe) && row == $past(row) && dark_line == $past(dark_line))
        |-> col == $past(col) + 1'b1);

    // R4
    row_mono_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_strobe && $past(pix_strobe)) |-> row >= $past(row));
endmodule

bind raster_win_gen rwg_chk u_rwg_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .row          (row),
    .col          (col),
    .dark_line    (dark_line),
    .pix_strobe   (pix_strobe),
    .frame_active (frame_active),
    .frame_done   (frame_done)
);

// File: tb/raster_win_gen_test.sv
`timescale 1ns/1ps
module raster_win_gen_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       frame_start = 1'b0;
    logic       dark_en_n = 1'b1;
    logic [7:0] win_start = 8'h00;
    logic [7:0] win_end = 8'h00;
    logic [6:0] row, col;
    logic       dark_line, pix_strobe, frame_active, frame_done;

    int checks = 0;
    int errors = 0;

    raster_win_gen uut (
        .clk          (clk),
        .rst_n        (rst_n),
        .frame_start  (frame_start),
        .win_start    (win_start),
        .win_end      (win_end),
        .dark_en_n    (dark_en_n),
        .row          (row),
        .col          (col),
        .dark_line    (dark_line),
        .pix_strobe   (pix_strobe),
        .frame_active (frame_active),
        .frame_done   (frame_done)
    );

    always #2 clk = ~clk;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic run_frame(input logic [7:0] s, input logic [7:0] e,
                             input logic dk_n, input string req, input bit disturb);
        int x0, y0, x1, y1, er, ec, npix, exp_n, bad, act_bad;
        bit edk, fin, prev_strobe, done_seen;
        x0 = int'(s[3:0]);
        y0 = int'(s[7:4]);
        x1 = (e[3:0] > s[3:0]) ? int'(e[3:0]) : 16;
        y1 = (e[7:4] > s[7:4]) ? int'(e[7:4]) : 16;
        exp_n = (x1 - x0) * 8 * (y1 - y0) * 8 + (dk_n ? 0 : 128);
        er = 8 * y0;
        ec = dk_n ? 8 * x0 : 0;
        edk = !dk_n;
        fin = 0; npix = 0; bad = 0; act_bad = 0;
        prev_strobe = 0; done_seen = 0;
        @(negedge clk);
        win_start = s; win_end = e; dark_en_n = dk_n; frame_start = 1'b1;
        @(negedge clk);
        frame_start = 1'b0;
        for (int cyc = 0; cyc < 20000 && !done_seen; cyc++) begin
            if (disturb && cyc == 5) begin
                win_start = 8'h00; win_end = 8'h00; dark_en_n = ~dk_n; frame_start = 1'b1;
            end
            if (disturb && cyc == 6) frame_start = 1'b0;
            if (pix_strobe) begin
                if (!frame_active) act_bad++;
                if (fin || int'(row) != er || int'(col) != ec || dark_line != edk) begin
                    bad++;
                    if (bad == 1)
                        $display("  mismatch pixel %0d: row=%0d col=%0d dark=%0b want row=%0d col=%0d dark=%0b",
                                 npix, row, col, dark_line, er, ec, edk);
                end
                if (edk) begin
                    if (ec == 127) begin edk = 0; ec = 8 * x0; end
                    else ec++;
                end else if (ec == 8 * x1 - 1) begin
                    if (er == 8 * y1 - 1) fin = 1;
                    else begin er++; ec = 8 * x0; end
                end else begin
                    ec++;
                end
                npix++;
            end
            if (frame_done) begin
                done_seen = 1;
                // R7 done comes the clock after the last pixel
                chk(prev_strobe && !pix_strobe && frame_active, "R7", "done timing",
                    int'(prev_strobe), 1);
            end
            prev_strobe = pix_strobe;
            @(negedge clk);
        end
        chk(done_seen, "R7", "frame_done seen", int'(done_seen), 1);
        chk(bad == 0, req, "pixel sequence mismatches", bad, 0);
        // R4 one pixel per window position
        chk(npix == exp_n, "R4", "pixel count", npix, exp_n);
        // R6 strobe only inside frame_active
        chk(act_bad == 0, "R6", "strobe outside frame_active", act_bad, 0);
        // R7 single pulse, R6 frame_active drops afterwards
        chk(!frame_done && !frame_active, "R7", "done/active after pulse",
            int'(frame_done) + int'(frame_active), 0);
        if (disturb) begin
            int extra = 0;
            for (int k = 0; k < 4; k++) begin
                if (pix_strobe || frame_active) extra++;
                @(negedge clk);
            end
            // R8 a start pulse while busy launches nothing
            chk(extra == 0, "R8", "activity after disturbed frame", extra, 0);
        end
    endtask

    task automatic t_reset();
        #1;
        // R9 outputs quiet in reset
        chk(!pix_strobe && !dark_line && !frame_active && !frame_done, "R9", "reset outputs",
            int'(pix_strobe) + int'(dark_line) + int'(frame_active) + int'(frame_done), 0);
        repeat (3) @(negedge clk);
        chk(!pix_strobe && !frame_active, "R9", "held reset outputs",
            int'(pix_strobe) + int'(frame_active), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk(!pix_strobe && !frame_done, "R9", "idle after reset",
            int'(pix_strobe) + int'(frame_done), 0);
    endtask

    initial begin
        #(4 * 190000);
        checks++;
        errors++;
        $display("FAIL watchdog run did not complete actual=timeout expected=finish");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        t_reset();
        run_frame(8'h00, 8'h00, 1'b1, "R2", 1'b0);
        run_frame(8'h21, 8'h63, 1'b1, "R1", 1'b0);
        run_frame(8'h00, 8'h10, 1'b1, "R3", 1'b0);
        run_frame(8'h55, 8'h33, 1'b1, "R3", 1'b0);
        run_frame(8'h12, 8'h34, 1'b0, "R5", 1'b0);
        run_frame(8'hF0, 8'h01, 1'b0, "R5", 1'b0);
        run_frame(8'h77, 8'h88, 1'b1, "R8", 1'b1);
        run_frame(8'h34, 8'h56, 1'b1, "R1", 1'b0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule